// File: doc/BRIEF.md
# Phase-Flagged Pair-Inversion Serializer

This block takes one parallel word at a time and sends it MSB first on a one-wire serial data line, next to a link clock. Its job is to cut the number of level changes on that line without adding a flag bit. It counts the level changes between neighbouring bits inside the word. If the count is above half the word length, it flips the second bit of every consecutive pair, read MSB first. It tells the receiver that the word was flipped by starting the data half a bit period late, so the data edges line up with the falling edge of the link clock instead of the rising one. A flip that would leave a flat word (all zeros or all ones) is not applied, because a flat word has no edges that could carry the phase.

The block runs on a clock at twice the bit rate, and every output changes at half-bit resolution. A bit occupies two consecutive cycles, called slots. Words enter through a valid/ready handshake. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the line is idle and falls in the cycle after acceptance. It stays low until the whole frame has been sent, including any late slot. While `in_ready` is low, `in_valid` and `in_data` are ignored, so the upstream source must hold its word until the block accepts it.

Top module: `txinv_phase_serializer`

## Requirements
- R1: The change count Nt is the number of neighbouring bit pairs inside the word that differ. The word is flipped only when Nt > WL/2 (for WL=8, Nt of 5 or more); a word with Nt of exactly WL/2 is sent unchanged.
- R2: Flipping inverts every bit at an even index counting from the LSB, which is the second bit of each MSB-first pair. For WL=8 this is XOR with 0x55, so 0xB4 is sent as 0xE1.
- R3: When the flipped word would be all zeros or all ones, for example 0x55 or 0xAA at WL=8, the word is sent unchanged and aligned.
- R4: Bits leave MSB first, and each bit is held on `ser_data` for two consecutive cycles.
- R5: An unflipped word takes 2*WL cycles. Its first bit appears in the cycle right after acceptance, and each bit starts in a slot where `lnk_clk` is high.
- R6: A flipped word takes 2*WL+1 cycles. In the first cycle after acceptance, `ser_data` keeps its previous level, and each bit then starts in a slot where `lnk_clk` is low.
- R7: Counting the first cycle after acceptance as slot 0, `lnk_clk` is 1 in the even slots 0 to 2*WL-2 and 0 in every other slot. It is 0 while the line is idle.
- R8: `in_ready` is 1 only when no frame is in progress. It is 0 from the cycle after acceptance until the last slot of the frame has passed. `in_valid` has no effect while `in_ready` is 0.
- R9: After reset, `in_ready` is 1, `lnk_clk` is 0 and `ser_data` is 0. Between frames, `ser_data` holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word is valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | WL | Parallel word, MSB sent first |
| ser_data | output | 1 | Serial data line, one level per slot |
| lnk_clk | output | 1 | Link clock, one level per slot |

## Verification
Every result belongs to a known slot. Slot s of a frame is visible in the (s+1)-th cycle after the accepting edge. `in_ready` returns 2*WL or 2*WL+1 cycles after acceptance, and the idle level follows one cycle after the last slot. The bench drives the word on a falling edge, lets the next rising edge accept it, and samples `ser_data`, `lnk_clk` and `in_ready` on every following falling edge, comparing each slot with the pattern predicted for that slot index. A word offered while the block is busy is placed inside a frame and withdrawn before `in_ready` returns, so any effect it had would show up as a wrong slot value or as a frame that starts unexpectedly.

// File: rtl/txinv_pkg.sv
package txinv_pkg;
  // Phase of a frame relative to the link clock
  typedef enum logic {
    PH_ALIGNED = 1'b0,
    PH_LATE    = 1'b1
  } txinv_phase_e;
endpackage

// File: rtl/txinv_transition_counter.sv
module txinv_transition_counter #(
  parameter int WL = 8,
  localparam int CW = $clog2(WL)
) (
  input  logic [WL-1:0] word,
  output logic [CW-1:0] count
);
  logic [WL-2:0] diff;

  // One flag for each neighbouring bit pair that differs
  genvar g;
  generate
    for (g = 0; g < WL-1; g++) begin : g_diff
      assign diff[g] = word[g] ^ word[g+1];
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int i = 0; i < WL-1; i++) count = count + CW'(diff[i]);
  end
endmodule

// File: rtl/txinv_pair_inverter.sv
module txinv_pair_inverter
  import txinv_pkg::*;
#(
  parameter int WL = 8,
  localparam int CW = $clog2(WL)
) (
  input  logic [WL-1:0]  word,
  input  logic [CW-1:0]  count,
  output logic [WL-1:0]  coded,
  output txinv_phase_e   phase
);
  localparam logic [CW-1:0] HALF = CW'(WL/2);

  logic [WL-1:0] mask;
  logic [WL-1:0] flipped;
  logic          want;
  logic          flat;

  // The second bit of each MSB-first pair sits at an even LSB index
  genvar g;
  generate
    for (g = 0; g < WL; g++) begin : g_mask
      assign mask[g] = (g % 2 == 0);
    end
  endgenerate

  assign flipped = word ^ mask;
  assign want    = count > HALF;
  assign flat    = (flipped == '0) || (&flipped);

  always_comb begin
    if (want && !flat) begin
      coded = flipped;
      phase = PH_LATE;
    end else begin
      coded = word;
      phase = PH_ALIGNED;
    end
  end
endmodule

// File: rtl/txinv_slot_shifter.sv
module txinv_slot_shifter
  import txinv_pkg::*;
#(
  parameter int WL = 8,
  localparam int SW = $clog2(2*WL+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WL-1:0] word,
  input  txinv_phase_e  phase,
  output logic          busy,
  output logic          ser_data,
  output logic          lnk_clk
);
  localparam logic [SW-1:0] LAST_AL = SW'(2*WL-1);
  localparam logic [SW-1:0] LAST_LT = SW'(2*WL);

  logic          busy_q;
  logic          late_q;
  logic          hold_q;
  logic [SW-1:0] slot_q;
  logic [WL-1:0] word_q;
  logic [SW-1:0] last_slot;
  logic [SW-1:0] eff_slot;
  logic [WL-1:0] aligned_word;

  assign last_slot = late_q ? LAST_LT : LAST_AL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      late_q <= 1'b0;
      hold_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      late_q <= (phase == PH_LATE);
      slot_q <= '0;
      word_q <= word;
    end else if (busy_q) begin
      if (slot_q == last_slot) begin
        busy_q <= 1'b0;
        hold_q <= word_q[0];
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  // A late frame spends its first slot on the previous level
  assign eff_slot     = slot_q - SW'(late_q);
  assign aligned_word = word_q << (eff_slot >> 1);

  always_comb begin
    if (!busy_q || (late_q && slot_q == '0)) ser_data = hold_q;
    else                                      ser_data = aligned_word[WL-1];
  end

  assign lnk_clk = busy_q && !slot_q[0] && (slot_q < LAST_LT);
  assign busy    = busy_q;

  // Each bit keeps its level through the second slot of its bit period
  p_bit_held_two_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && slot_q != '0 && (slot_q[0] != late_q)) |-> ser_data == $past(ser_data));

  // The idle line keeps the last bit sent
  p_idle_line_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> $stable(ser_data));

  // A frame never runs past its final slot
  p_frame_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> slot_q <= last_slot);

  // The late slot repeats the level that was on the line before the frame
  p_late_start_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && late_q && slot_q == '0) |-> ser_data == $past(ser_data));
endmodule

// File: rtl/txinv_phase_serializer.sv
module txinv_phase_serializer
  import txinv_pkg::*;
#(
  parameter int WL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [WL-1:0] in_data,
  output logic          ser_data,
  output logic          lnk_clk
);
  localparam int CW = $clog2(WL);

  logic [CW-1:0] nt;
  logic [WL-1:0] coded;
  txinv_phase_e  phase;
  logic          busy;
  logic          load;

  assign in_ready = !busy;
  assign load     = in_valid && in_ready;

  txinv_transition_counter #(.WL(WL)) u_count (
    .word  (in_data),
    .count (nt)
  );

  txinv_pair_inverter #(.WL(WL)) u_invert (
    .word  (in_data),
    .count (nt),
    .coded (coded),
    .phase (phase)
  );

  txinv_slot_shifter #(.WL(WL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word     (coded),
    .phase    (phase),
    .busy     (busy),
    .ser_data (ser_data),
    .lnk_clk  (lnk_clk)
  );

  initial begin
    if (WL % 2 != 0 || WL < 4) $error("WL must be even and at least 4");
  end

  // Ready drops in the cycle after a word is taken
  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // A late frame only follows a word whose change count exceeds WL/2
  p_late_needs_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && phase == PH_LATE) |-> nt > CW'(WL/2));

  // A late frame never carries a flat word
  p_no_flat_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && phase == PH_LATE) |-> (coded != '0 && !(&coded)));

  // The link clock stays low while no frame is in progress
  p_clock_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !lnk_clk);
endmodule

// File: tb/txinv_phase_serializer_bench.sv
`timescale 1ns/1ps
module txinv_phase_serializer_bench;
  localparam int WL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [WL-1:0] in_data = '0;
  logic          in_ready;
  logic          ser_data;
  logic          lnk_clk;

  int checks = 0;
  int fails  = 0;
  logic last_bit = 1'b0;

  always #4 clk = ~clk;

  txinv_phase_serializer #(.WL(WL)) u_txinv_phase_serializer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .ser_data (ser_data),
    .lnk_clk  (lnk_clk)
  );

  // {word, sent word, late, tag code}; results worked out by hand for WL=8
  localparam logic [18:0] VEC [12] = '{
    {8'hB4, 8'hE1, 1'b1, 2'd1},  // R2: Nt=5, flip
    {8'h5A, 8'h0F, 1'b1, 2'd1},  // R2: Nt=6
    {8'hD2, 8'h87, 1'b1, 2'd1},  // R2: Nt=5
    {8'hA9, 8'hFC, 1'b1, 2'd1},  // R2: Nt=6
    {8'h6B, 8'h3E, 1'b1, 2'd1},  // R2: Nt=5
    {8'h66, 8'h66, 1'b0, 2'd0},  // R1: Nt=4, exactly at threshold
    {8'h33, 8'h33, 1'b0, 2'd0},  // R1: Nt=3
    {8'h0F, 8'h0F, 1'b0, 2'd0},  // R1: Nt=1
    {8'hAA, 8'hAA, 1'b0, 2'd2},  // R3: flip would give 0xFF
    {8'h55, 8'h55, 1'b0, 2'd2},  // R3: flip would give 0x00
    {8'hFF, 8'hFF, 1'b0, 2'd3},  // R4: flat word
    {8'h00, 8'h00, 1'b0, 2'd3}   // R4: flat word
  };

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [WL-1:0] ref_code(input logic [WL-1:0] w, output logic late);
    int n = 0;
    logic [WL-1:0] f;
    for (int i = 0; i < WL-1; i++) if (w[i] != w[i+1]) n++;
    f = w;
    for (int i = 0; i < WL; i += 2) f[i] = ~f[i];
    late = (n > WL/2) && (f != '0) && !(&f);
    return late ? f : w;
  endfunction

  // Offer a word, then check every slot of its frame and the idle cycle after it
  task automatic run_frame(input logic [WL-1:0] w, input logic [WL-1:0] e,
                           input logic lt, input string req, input bit poke);
    int  n = 2*WL + (lt ? 1 : 0);
    int  k;
    logic ed;
    @(negedge clk);
    chk(in_ready, 1'b1, "R8", "ready before offer");
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    for (int s = 0; s < n; s++) begin
      if (poke && s == 3) begin in_valid = 1'b1; in_data = ~w; end
      if (poke && s == 6) begin in_valid = 1'b0; in_data = '0; end
      if (lt && s == 0) ed = last_bit;
      else begin
        k  = (lt ? s - 1 : s) / 2;
        ed = e[WL-1-k];
      end
      chk(ser_data, ed, lt ? "R6" : req, "data slot");
      chk(lnk_clk, (s < 2*WL) && (s % 2 == 0), "R7", "link clock slot");
      chk(in_ready, 1'b0, "R8", "ready during frame");
      @(negedge clk);
    end
    chk(in_ready, 1'b1, lt ? "R6" : "R5", "ready after frame length");
    chk(lnk_clk, 1'b0, "R7", "clock idle");
    chk(ser_data, e[0], "R9", "idle holds last bit");
    last_bit = e[0];
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [WL-1:0] w;
    logic [WL-1:0] e;
    logic          lt;
    logic [15:0]   lfsr = 16'hACE1;
    string         tags [4] = '{"R1", "R2", "R3", "R4"};

    repeat (3) @(negedge clk);
    chk(in_ready, 1'b1, "R9", "reset ready");
    chk(lnk_clk, 1'b0, "R9", "reset clock");
    chk(ser_data, 1'b0, "R9", "reset data");
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, 1'b1, "R9", "ready after reset");

    for (int i = 0; i < 12; i++) begin
      w  = VEC[i][18:11];
      e  = VEC[i][10:3];
      lt = VEC[i][2];
      run_frame(w, e, lt, tags[VEC[i][1:0]], 1'b0);
    end

    // Frame ending in 1, then a late frame: the late slot repeats that 1
    run_frame(8'h0F, 8'h0F, 1'b0, "R5", 1'b0);
    run_frame(8'hB4, 8'hE1, 1'b1, "R6", 1'b0);

    // A word offered mid-frame must not disturb the frame or start another
    run_frame(8'hD2, 8'h87, 1'b1, "R8", 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(lnk_clk, 1'b0, "R8", "no frame from ignored word");
      chk(ser_data, last_bit, "R8", "line idle after ignored word");
    end

    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = lfsr[WL-1:0];
      e = ref_code(w, lt);
      run_frame(w, e, lt, "R1", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule